// File: doc/BRIEF.md
# Shared GPIO Port with Nibble-Owned SPI Override

An 8-pin general-purpose port is reached through a small register bus. The pins are split into two groups of four. Each group can be claimed by one serial peripheral. While that peripheral is enabled, it supplies the drive value and the driver enable for its four pins. A released pin is controlled by the port's own data latch and direction register. Every pin is passed through a two-flop synchronizer. The synchronized levels serve the register readback, and they are also returned to both peripherals as their input lanes.

Software sees three byte registers.

- **Data latch, offset 0x20.** Reads are mixed per bit: a pin configured as an output returns its latch bit, and a pin configured as an input returns its synchronized level.
- **Pin-level register, offset 0x21.** It always shows the synchronized pins, and writes to it are ignored.
- **Direction register, offset 0x22.**

Read data is registered and appears one cycle after the address. The latch keeps accepting writes while a peripheral owns the pins, so a value can be staged before the peripheral is released.

Top module: `spi_gpio_port`

## Requirements
- R1: While `spi_en[1]` is 1 and reset is released, `pin_out[7:4]` equals `spi_out[7:4]` and `pin_oe[7:4]` equals `spi_oe[7:4]`.
- R2: While `spi_en[0]` is 1 and reset is released, `pin_out[3:0]` equals `spi_out[3:0]` and `pin_oe[3:0]` equals `spi_oe[3:0]`.
- R3: On a pin whose group is not owned, `pin_oe` equals the direction bit and `pin_out` equals the data latch bit.
- R4: While `rst_n` is 0, `pin_oe` is all zeros regardless of `spi_en`. After reset, the data latch and direction register both read 0.
- R5: A write to offset 0x20 loads the data latch. A read of 0x20 returns, bit by bit, the latch bit where the direction bit is 1 and the synchronized pin where it is 0.
- R6: A read of offset 0x21 returns the synchronized pin levels. A write to 0x21 changes neither register. The synchronizer is not cleared by reset, so the pin levels read back in the first cycle after reset.
- R7: Offset 0x22 is the direction register, readable and writable, with 1 meaning output.
- R8: A pin change shows on `spi_in` two clock edges later and in read data three edges later.
- R9: `bus_rdata` reflects the address presented before the previous clock edge. Unmapped offsets read 0, and `bus_rdata` is 0 after reset.
- R10: Writes to 0x20 while a group is owned still update the latch, and that value drives the pins once the owner is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad drive values |
| pin_oe | output | 8 | Pad driver enables, 1 means driven |
| spi_en | input | 2 | Owner enables: bit 0 claims pins 3:0, bit 1 claims pins 7:4 |
| spi_out | input | 8 | Peripheral drive values, one lane per pin |
| spi_oe | input | 8 | Peripheral driver enables, one lane per pin |
| spi_in | output | 8 | Synchronized pin levels returned to the peripherals |

## Verification
The bench builds the block with its defaults: eight pins, two owner groups of four and a two-stage synchronizer. This keeps the byte-wide space small enough to cover completely. Every one of the 256 direction values is swept against computed latch and pin patterns, which covers each possible per-bit readback mix. All four owner-enable combinations are crossed with sixteen peripheral patterns, which covers every nibble ownership split. Directed sequences cover the synchronizer latency, staging a latch value under ownership, writes to the pin-level register, and the pin levels surviving reset.

// File: rtl/spi_gpio_pkg.sv
// Shared constants and decode helpers for the shared GPIO port.
// Assumes a byte-addressed register window with fixed offsets.
package spi_gpio_pkg;
    localparam int ADDR_W = 8;
    localparam logic [ADDR_W-1:0] OFS_DATA = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_IN   = 8'h21;
    localparam logic [ADDR_W-1:0] OFS_DIR  = 8'h22;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_DATA = 2'd1,
        SEL_IN   = 2'd2,
        SEL_DIR  = 2'd3
    } reg_sel_e;

    // Map an offset to the register it selects.
    function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_DATA: return SEL_DATA;
            OFS_IN:   return SEL_IN;
            OFS_DIR:  return SEL_DIR;
            default:  return SEL_NONE;
        endcase
    endfunction
endpackage

// File: rtl/pin_sync.sv
// Multi-stage synchronizer for the pad inputs.
// It deliberately has no reset, so the sampled levels survive a reset.
// Assumes STAGES >= 1.
module pin_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // First stage captures the asynchronous pad levels.
    always_ff @(posedge clk) begin
        stg[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Each later stage re-registers the previous one.
        always_ff @(posedge clk) begin
            stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/port_regs.sv
// Register file for the port: data latch, direction register and registered read mux.
// Assumes the offsets in spi_gpio_pkg. The pin-level register has no storage of its own.
module port_regs
    import spi_gpio_pkg::*;
#(
    parameter int W  = 8,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic [W-1:0]  bus_wdata,
    input  logic [W-1:0]  pins_sync,
    output logic [W-1:0]  data_q,
    output logic [W-1:0]  dir_q,
    output logic [W-1:0]  bus_rdata
);
    reg_sel_e     sel;
    logic [W-1:0] rd_next;

    assign sel = decode_ofs(bus_addr);

    // Data latch: written through the bus at any time, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                       data_q <= '0;
        else if (bus_we && sel == SEL_DATA) data_q <= bus_wdata;
    end

    // Direction register: 1 marks an output, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                      dir_q <= '0;
        else if (bus_we && sel == SEL_DIR) dir_q <= bus_wdata;
    end

    // Read mux: a data read mixes latch and pin bits according to the direction register.
    always_comb begin
        case (sel)
            SEL_DATA: rd_next = (data_q & dir_q) | (pins_sync & ~dir_q);
            SEL_IN:   rd_next = pins_sync;
            SEL_DIR:  rd_next = dir_q;
            default:  rd_next = '0;
        endcase
    end

    // Read data register: the value appears one cycle after the address.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= '0;
        else        bus_rdata <= rd_next;
    end

    // R7: a direction write lands in the following cycle.
    p_dir_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_DIR) |=> (dir_q == $past(bus_wdata)));

    // R6: a write to the pin-level register leaves both registers untouched.
    p_in_nowrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_IN) |=> (data_q == $past(data_q) && dir_q == $past(dir_q)));

    // R9: an unmapped offset reads zero in the next cycle.
    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != OFS_DATA && bus_addr != OFS_IN && bus_addr != OFS_DIR) |=> (bus_rdata == '0));

    // R6: the pin-level read returns the synchronized pins of the previous cycle.
    p_in_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_IN) |=> (bus_rdata == $past(pins_sync)));
endmodule

// File: rtl/owner_mux.sv
// Per-group pin ownership: an enabled peripheral overrides GPIO on its group of pins.
// Assumes W divides evenly into GROUPS groups. Group g covers pins [g*GW +: GW].
module owner_mux #(
    parameter int W      = 8,
    parameter int GROUPS = 2
) (
    input  logic              rst_n,
    input  logic [GROUPS-1:0] grp_en,
    input  logic [W-1:0]      gpio_out,
    input  logic [W-1:0]      gpio_oe,
    input  logic [W-1:0]      per_out,
    input  logic [W-1:0]      per_oe,
    output logic [W-1:0]      pin_out,
    output logic [W-1:0]      pin_oe
);
    localparam int GW = W / GROUPS;

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        // Select the owner of this group and gate the drivers while reset is held.
        always_comb begin
            if (grp_en[g]) begin
                pin_out[g*GW +: GW] = per_out[g*GW +: GW];
                pin_oe[g*GW +: GW]  = rst_n ? per_oe[g*GW +: GW] : '0;
            end else begin
                pin_out[g*GW +: GW] = gpio_out[g*GW +: GW];
                pin_oe[g*GW +: GW]  = rst_n ? gpio_oe[g*GW +: GW] : '0;
            end
        end
    end

    // R4: no pad is driven while reset is held.
    always_comb begin
        if (rst_n == 1'b0) begin
            p_oe_off_reset_r4: assert (pin_oe == '0);
        end
    end
endmodule

// File: rtl/spi_gpio_port.sv
// Top level of the shared GPIO port. It ties together the input synchronizer,
// the register file and the per-group ownership multiplexer.
// Assumes synchronous active-low reset. spi_en[g] claims pins [g*4 +: 4] with the defaults.
module spi_gpio_port
    import spi_gpio_pkg::*;
#(
    parameter int NPINS       = 8,
    parameter int NOWNERS     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [NPINS-1:0]   bus_wdata,
    output logic [NPINS-1:0]   bus_rdata,
    input  logic [NPINS-1:0]   pin_in,
    output logic [NPINS-1:0]   pin_out,
    output logic [NPINS-1:0]   pin_oe,
    input  logic [NOWNERS-1:0] spi_en,
    input  logic [NPINS-1:0]   spi_out,
    input  logic [NPINS-1:0]   spi_oe,
    output logic [NPINS-1:0]   spi_in
);
    localparam int GW = NPINS / NOWNERS;

    logic [NPINS-1:0] pins_s;
    logic [NPINS-1:0] data_q;
    logic [NPINS-1:0] dir_q;

    pin_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .d   (pin_in),
        .q   (pins_s)
    );

    port_regs #(.W(NPINS), .AW(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .pins_sync (pins_s),
        .data_q    (data_q),
        .dir_q     (dir_q),
        .bus_rdata (bus_rdata)
    );

    owner_mux #(.W(NPINS), .GROUPS(NOWNERS)) u_own (
        .rst_n    (rst_n),
        .grp_en   (spi_en),
        .gpio_out (data_q),
        .gpio_oe  (dir_q),
        .per_out  (spi_out),
        .per_oe   (spi_oe),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe)
    );

    assign spi_in = pins_s;

    // R1: the upper group follows its peripheral while that peripheral is enabled.
    p_upper_owned_r1: assert property (@(posedge clk) disable iff (!rst_n)
        spi_en[NOWNERS-1] |-> (pin_out[NPINS-1 -: GW] == spi_out[NPINS-1 -: GW]
                               && pin_oe[NPINS-1 -: GW] == spi_oe[NPINS-1 -: GW]));

    // R2: the lower group follows its peripheral while that peripheral is enabled.
    p_lower_owned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        spi_en[0] |-> (pin_out[GW-1:0] == spi_out[GW-1:0] && pin_oe[GW-1:0] == spi_oe[GW-1:0]));

    if (SYNC_STAGES == 2) begin : g_lat_chk
        // R8: the peripheral input lanes carry the pad levels of two edges ago.
        p_sync_two_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n, 2) |-> (spi_in == $past(pin_in, 2)));
    end
endmodule

// File: tb/sim_spi_gpio_port.sv
// Self-checking bench: full sweeps of direction and ownership, plus directed corner cases.
module sim_spi_gpio_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;
    logic [1:0] spi_en = 2'b00;
    logic [7:0] spi_out = 8'h00;
    logic [7:0] spi_oe = 8'h00;
    logic [7:0] spi_in;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] rv;

    spi_gpio_port u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .spi_en(spi_en),
        .spi_out(spi_out), .spi_oe(spi_oe), .spi_in(spi_in)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic set_pins(input logic [7:0] p);
        @(negedge clk);
        pin_in = p;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #1500000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R4: drivers stay off during reset even when both groups are enabled.
        pin_in = 8'hA5; spi_en = 2'b11; spi_oe = 8'hFF;
        repeat (4) @(negedge clk);
        chk("R4 oe during reset", pin_oe, 8'h00);
        spi_en = 2'b00; spi_oe = 8'h00;
        // R6: release reset with the pins stable; the pin levels read back in the first cycle.
        bus_addr = 8'h21;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R6 levels survive reset", bus_rdata, 8'hA5);
        rd(8'h22, rv); chk("R4 dir reset", rv, 8'h00);
        rd(8'h22, rv); chk("R7 dir reads 0", rv, 8'h00);
        wr(8'h22, 8'hFF);
        rd(8'h20, rv); chk("R4 data reset", rv, 8'h00);
        wr(8'h22, 8'h00);
        rd(8'h20, rv); chk("R5 data reads pins when dir 0", rv, 8'hA5);
        rd(8'h3C, rv); chk("R9 unmapped reads 0", rv, 8'h00);

        // R5/R3/R7: sweep all direction values against computed latch and pin patterns.
        for (int k = 0; k < 256; k++) begin
            logic [7:0] dv, dd, pp;
            dv = 8'(k);
            dd = 8'(k * 37 + 5);
            pp = ~dv ^ 8'h5A;
            wr(8'h22, dv);
            wr(8'h20, dd);
            set_pins(pp);
            rd(8'h20, rv); chk("R5 mixed readback", rv, (dd & dv) | (pp & ~dv));
            chk("R3 oe from dir", pin_oe, dv);
            chk("R3 out from latch", pin_out, dd);
            if ((k % 16) == 0) begin
                rd(8'h22, rv); chk("R7 dir readback", rv, dv);
                rd(8'h21, rv); chk("R6 level readback", rv, pp);
            end
        end

        // R1/R2: every ownership split crossed with sixteen peripheral patterns.
        wr(8'h22, 8'h3C);
        wr(8'h20, 8'h96);
        for (int e = 0; e < 4; e++) begin
            for (int j = 0; j < 16; j++) begin
                logic [7:0] eo, ee, m;
                @(negedge clk);
                spi_en = 2'(e);
                spi_out = 8'(j * 17) ^ 8'hC3;
                spi_oe = 8'(j * 29 + 1);
                #1;
                m = {{4{e[1]}}, {4{e[0]}}};
                eo = (spi_out & m) | (8'h96 & ~m);
                ee = (spi_oe & m) | (8'h3C & ~m);
                if (e[1]) chk("R1 upper owned out", pin_out, eo);
                else      chk("R2 lower owner split out", pin_out, eo);
                if (e[0]) chk("R2 lower owned oe", pin_oe, ee);
                else      chk("R1 upper owner split oe", pin_oe, ee);
            end
        end

        // R10: stage a value in the latch while both groups are owned, then release.
        @(negedge clk); spi_en = 2'b11; spi_out = 8'h0F; spi_oe = 8'hF0;
        wr(8'h20, 8'h5B);
        wr(8'h22, 8'hFF);
        #1 chk("R10 owned pins ignore latch", pin_out, 8'h0F);
        @(negedge clk); spi_en = 2'b00;
        #1 chk("R10 latch drives after release", pin_out, 8'h5B);
        chk("R10 oe after release", pin_oe, 8'hFF);

        // R6: a write to the pin-level register changes nothing.
        wr(8'h21, 8'h00);
        rd(8'h20, rv); chk("R6 write ignored data", rv, 8'h5B);
        rd(8'h22, rv); chk("R6 write ignored dir", rv, 8'hFF);

        // R8/R9: latency from a pin change to spi_in and to read data.
        wr(8'h22, 8'h00);
        set_pins(8'h11);
        @(negedge clk); bus_addr = 8'h21; pin_in = 8'hEE;
        @(negedge clk);
        chk("R8 spi_in after 1 edge", spi_in, 8'h11);
        chk("R9 rdata after 1 edge", bus_rdata, 8'h11);
        @(negedge clk);
        chk("R8 spi_in after 2 edges", spi_in, 8'hEE);
        chk("R8 rdata after 2 edges", bus_rdata, 8'h11);
        @(negedge clk);
        chk("R8 rdata after 3 edges", bus_rdata, 8'hEE);

        // R9: read data follows the address of the previous cycle.
        @(negedge clk); bus_addr = 8'h22;
        @(negedge clk); chk("R9 addr switch", bus_rdata, 8'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule